// File: doc/BRIEF.md
# GPIO interrupt detection controller

This block watches 32 general-purpose input pins and turns activity on them into one interrupt request for a processor. Each pin is set up on its own. It can be a level source with a chosen active polarity, or an edge source that reacts to rising edges, falling edges or both. An edge source either latches its event until software clears it or reports it as a one-cycle pulse. Pin inputs are asynchronous and pass through a synchroniser before any detection happens.

Software reaches the block through a 16-bit register port. Every per-pin setting is split into a pair of halfword registers. Pins 0 to 15 use bit n of the low register, and pins 16 to 31 use bit n-16 of the high register, which sits two bytes above the low one. The block masks pending status with per-pin enables and drives a combined request. Alongside it, the block reports the number of the lowest pending and enabled pin so that a dispatcher can service it without a scan.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Configuration registers read back what was written, at these byte offsets (low/high): enable 0x0C/0x0E, trigger type 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling qualifier 0x20/0x22, rising qualifier 0x24/0x26. A write to one bank leaves the other bank unchanged.
- R2: After reset all enables and settings read as zero, and irq, pend_valid and pend_pin are all 0.
- R3: Writing 1 to a bit of the status register (0x08 low, 0x0A high) clears that pin's latched edge. Writing 0 to a status bit has no effect.
- R4: With the type bit at 0 (level mode), status follows the qualified input. Polarity bit 1 means the pin is active while high, and polarity bit 0 means active while low. Writing 1 to status cannot clear the bit while the level stays active.
- R5: With the type bit at 1 (edge mode), a rising edge sets status only when the rising-qualifier bit is 1, and a falling edge sets status only when the falling-qualifier bit is 1. With both qualifier bits at 0 the pin never sets status.
- R6: In edge mode with the hold bit at 1, a detected edge stays in status across any number of cycles until a write of 1 clears it.
- R7: In edge mode with the hold bit at 0, a detected edge makes status high for exactly one cycle.
- R8: irq is the OR over all pins of status AND enable. A pending pin whose enable bit is 0 still shows in status but does not raise irq.
- R9: pend_pin is the lowest-numbered pin that is both pending and enabled, so every low-bank pin wins over every high-bank pin. pend_valid equals irq. When nothing is pending, pend_pin is 0.
- R10: Reads at undefined offsets, or at odd addresses, return zero. Writes there change nothing.
- R11: A change on a pin input reaches status on the third rising clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Asynchronous pin inputs |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Combined interrupt request |
| pend_valid | output | 1 | A pending and enabled pin exists |
| pend_pin | output | 5 | Number of the lowest pending and enabled pin |

## Verification
The bench builds the block with its default 16-bit bank width, which gives the full 32-pin, two-bank map and a 5-bit pin number. At this width the bank boundary between pins 15 and 16 can be tested, where the priority order crosses from the low register set to the high one. The default two-stage synchroniser makes the three-edge input latency visible at the ports. The random phase mixes pin toggles with writes to every defined register in both banks, so clears, mode switches and enable changes can land in the same cycle as detected edges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_AW = 6;

  // Per-pin detection settings gathered from the register pairs.
  typedef struct packed {
    logic edge_mode;
    logic act_high;
    logic hold;
    logic fall_q;
    logic rise_q;
  } pin_cfg_t;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_STAT,
    RS_EN,
    RS_TYPE,
    RS_LVL,
    RS_HOLD,
    RS_FALL,
    RS_RISE
  } reg_sel_e;

  // Word-group decode: byte address bits [5:2].
  function automatic reg_sel_e decode_group(input logic [3:0] grp);
    reg_sel_e sel;
    case (grp)
      4'd2:    sel = RS_STAT;
      4'd3:    sel = RS_EN;
      4'd4:    sel = RS_TYPE;
      4'd5:    sel = RS_LVL;
      4'd6:    sel = RS_HOLD;
      4'd8:    sel = RS_FALL;
      4'd9:    sel = RS_RISE;
      default: sel = RS_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < DEPTH; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
  assign prev_o = stage_q[STAGES];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cur_i,
  input  logic     prev_i,
  input  pin_cfg_t cfg_i,
  input  logic     clr_i,
  output logic     status_o
);

  logic status_q;
  logic status_d;
  logic rise_hit;
  logic fall_hit;
  logic edge_hit;
  logic level_on;

  always_comb begin
    rise_hit = cur_i & ~prev_i & cfg_i.rise_q;
    fall_hit = ~cur_i & prev_i & cfg_i.fall_q;
    edge_hit = rise_hit | fall_hit;
    level_on = cfg_i.act_high ? cur_i : ~cur_i;
    if (!cfg_i.edge_mode) begin
      status_d = level_on;
    end else if (cfg_i.hold) begin
      status_d = (status_q & ~clr_i) | edge_hit;
    end else begin
      status_d = edge_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else begin
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IDX_W'(i);
        valid_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned BANK_W   = 16,
  parameter int unsigned NUM_PINS = 2 * BANK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] status_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] typ_o,
  output logic [NUM_PINS-1:0] lvl_o,
  output logic [NUM_PINS-1:0] hold_o,
  output logic [NUM_PINS-1:0] fall_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] clr_o
);

  reg_sel_e            sel;
  int unsigned         bank_idx;
  logic [NUM_PINS-1:0] wmask;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] rd_vec;

  logic [NUM_PINS-1:0] en_q, typ_q, lvl_q, hold_q, fall_q, rise_q;
  logic [NUM_PINS-1:0] en_d, typ_d, lvl_d, hold_d, fall_d, rise_d;
  logic                en_we, typ_we, lvl_we, hold_we, fall_we, rise_we;

  function automatic logic [NUM_PINS-1:0] merge(input logic [NUM_PINS-1:0] old_v,
                                                input logic [NUM_PINS-1:0] m,
                                                input logic [NUM_PINS-1:0] b);
    return (old_v & ~m) | (b & m);
  endfunction

  always_comb begin
    sel      = RS_NONE;
    if (bus_sel && !bus_addr[0]) begin
      sel = decode_group(bus_addr[BUS_AW-1:2]);
    end
    bank_idx = bus_addr[1] ? 1 : 0;
    wmask    = '0;
    wbits    = '0;
    wmask[bank_idx*BANK_W +: BANK_W] = '1;
    wbits[bank_idx*BANK_W +: BANK_W] = bus_wdata;
  end

  // Clock enables and next values.
  always_comb begin
    en_we   = bus_wr && (sel == RS_EN);
    typ_we  = bus_wr && (sel == RS_TYPE);
    lvl_we  = bus_wr && (sel == RS_LVL);
    hold_we = bus_wr && (sel == RS_HOLD);
    fall_we = bus_wr && (sel == RS_FALL);
    rise_we = bus_wr && (sel == RS_RISE);
    en_d    = merge(en_q, wmask, wbits);
    typ_d   = merge(typ_q, wmask, wbits);
    lvl_d   = merge(lvl_q, wmask, wbits);
    hold_d  = merge(hold_q, wmask, wbits);
    fall_d  = merge(fall_q, wmask, wbits);
    rise_d  = merge(rise_q, wmask, wbits);
    clr_o   = (bus_wr && (sel == RS_STAT)) ? wbits : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      typ_q  <= '0;
      lvl_q  <= '0;
      hold_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (typ_we)  typ_q  <= typ_d;
      if (lvl_we)  lvl_q  <= lvl_d;
      if (hold_we) hold_q <= hold_d;
      if (fall_we) fall_q <= fall_d;
      if (rise_we) rise_q <= rise_d;
    end
  end

  always_comb begin
    case (sel)
      RS_STAT: rd_vec = status_i;
      RS_EN:   rd_vec = en_q;
      RS_TYPE: rd_vec = typ_q;
      RS_LVL:  rd_vec = lvl_q;
      RS_HOLD: rd_vec = hold_q;
      RS_FALL: rd_vec = fall_q;
      RS_RISE: rd_vec = rise_q;
      default: rd_vec = '0;
    endcase
    bus_rdata = (bus_sel && !bus_wr) ? rd_vec[bank_idx*BANK_W +: BANK_W] : '0;
  end

  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign lvl_o  = lvl_q;
  assign hold_o = hold_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter  int unsigned BANK_W      = 16,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_PINS    = 2 * BANK_W,
  localparam int unsigned PIN_W       = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  output logic                irq,
  output logic                pend_valid,
  output logic [PIN_W-1:0]    pend_pin
);

  logic [1:0]          rst_q;
  logic                rst_int_n;
  logic [NUM_PINS-1:0] pin_cur, pin_prev;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] en_q, typ_w, lvl_w, hold_w, fall_w, rise_w, clr_w;
  logic [NUM_PINS-1:0] pend_req;
  pin_cfg_t            cfg_q [NUM_PINS];

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_q[1];

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (pin_in),
    .sync_o  (pin_cur),
    .prev_o  (pin_prev)
  );

  gpio_irq_regs #(.BANK_W(BANK_W), .NUM_PINS(NUM_PINS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .status_i  (status_q),
    .en_o      (en_q),
    .typ_o     (typ_w),
    .lvl_o     (lvl_w),
    .hold_o    (hold_w),
    .fall_o    (fall_w),
    .rise_o    (rise_w),
    .clr_o     (clr_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign cfg_q[p] = '{edge_mode: typ_w[p], act_high: lvl_w[p], hold: hold_w[p],
                        fall_q: fall_w[p], rise_q: rise_w[p]};
    gpio_irq_detect det_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cur_i    (pin_cur[p]),
      .prev_i   (pin_prev[p]),
      .cfg_i    (cfg_q[p]),
      .clr_i    (clr_w[p]),
      .status_o (status_q[p])
    );
  end

  assign pend_req = status_q & en_q;
  assign irq      = |pend_req;

  gpio_irq_prio #(.N(NUM_PINS), .IDX_W(PIN_W)) prio_i (
    .req_i   (pend_req),
    .valid_o (pend_valid),
    .idx_o   (pend_pin)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned PIN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq,
  input logic                pend_valid,
  input logic [PIN_W-1:0]    pend_pin,
  input logic [NUM_PINS-1:0] stat,
  input logic [NUM_PINS-1:0] en,
  input logic [NUM_PINS-1:0] edge_v,
  input logic [NUM_PINS-1:0] hold_v,
  input logic [NUM_PINS-1:0] fall_v,
  input logic [NUM_PINS-1:0] clr
);

  logic [NUM_PINS-1:0] one_hot;
  logic [NUM_PINS-1:0] below;

  always_comb begin
    one_hot = {{(NUM_PINS-1){1'b0}}, 1'b1} << pend_pin;
    below   = one_hot - {{(NUM_PINS-1){1'b0}}, 1'b1};
  end

  assert_valid_eq_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid == irq);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en));

  assert_pin_pending_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (stat[pend_pin] && en[pend_pin]));

  assert_pin_is_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> ((stat & en & below) == '0));

  assert_idle_pin_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid |-> (pend_pin == '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    assert_hold_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v[p] && hold_v[p] && stat[p] && !clr[p]) |=> stat[p]);

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v[p] && !hold_v[p] && !fall_v[p] && stat[p]) |=> !stat[p]);
  end

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .irq        (irq),
  .pend_valid (pend_valid),
  .pend_pin   (pend_pin),
  .stat       (status_q),
  .en         (en_q),
  .edge_v     (typ_w),
  .hold_v     (hold_w),
  .fall_v     (fall_w),
  .clr        (clr_w)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic        pend_valid;
  logic [4:0]  pend_pin;

  int n_chk = 0;
  int n_err = 0;
  logic chk_on = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pins),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend_valid(pend_valid),
    .pend_pin  (pend_pin)
  );

  // Reference model built from the requirements.
  logic [31:0] m_en, m_typ, m_lvl, m_hold, m_fall, m_rise, m_stat;
  logic [31:0] m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] wm, wb, clr, ev;
    if (!rst_n) begin
      m_en <= '0; m_typ <= '0; m_lvl <= '0; m_hold <= '0;
      m_fall <= '0; m_rise <= '0; m_stat <= '0;
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
    end else begin
      wm  = bus_addr[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      wb  = bus_addr[1] ? {bus_wdata, 16'h0} : {16'h0, bus_wdata};
      clr = '0;
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          6'h08, 6'h0A: clr = wb;
          6'h0C, 6'h0E: m_en   <= (m_en   & ~wm) | wb;
          6'h10, 6'h12: m_typ  <= (m_typ  & ~wm) | wb;
          6'h14, 6'h16: m_lvl  <= (m_lvl  & ~wm) | wb;
          6'h18, 6'h1A: m_hold <= (m_hold & ~wm) | wb;
          6'h20, 6'h22: m_fall <= (m_fall & ~wm) | wb;
          6'h24, 6'h26: m_rise <= (m_rise & ~wm) | wb;
          default: ;
        endcase
      end
      ev = (m_s2 & ~m_s3 & m_rise) | (~m_s2 & m_s3 & m_fall);
      for (int p = 0; p < 32; p++) begin
        if (!m_typ[p])      m_stat[p] <= m_lvl[p] ? m_s2[p] : ~m_s2[p];
        else if (m_hold[p]) m_stat[p] <= (m_stat[p] & ~clr[p]) | ev[p];
        else                m_stat[p] <= ev[p];
      end
      m_s1 <= pins; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  function automatic logic [15:0] model_read(input logic [5:0] a);
    case (a)
      6'h08: return m_stat[15:0];  6'h0A: return m_stat[31:16];
      6'h0C: return m_en[15:0];    6'h0E: return m_en[31:16];
      6'h10: return m_typ[15:0];   6'h12: return m_typ[31:16];
      6'h14: return m_lvl[15:0];   6'h16: return m_lvl[31:16];
      6'h18: return m_hold[15:0];  6'h1A: return m_hold[31:16];
      6'h20: return m_fall[15:0];  6'h22: return m_fall[31:16];
      6'h24: return m_rise[15:0];  6'h26: return m_rise[31:16];
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [5:0] exp_pin(input logic [31:0] req);
    for (int p = 0; p < 32; p++) if (req[p]) return 6'(p);
    return 6'd0;
  endfunction

  function automatic logic [5:0] pick_addr(input int unsigned k);
    case (k % 16)
      0: return 6'h08;  1: return 6'h0A;  2: return 6'h0C;  3: return 6'h0E;
      4: return 6'h10;  5: return 6'h12;  6: return 6'h14;  7: return 6'h16;
      8: return 6'h18;  9: return 6'h1A; 10: return 6'h20; 11: return 6'h22;
      12: return 6'h24; 13: return 6'h26; 14: return 6'h1C; default: return 6'h0B;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle output comparison against the model (R8, R9).
  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R8 irq vs model", 32'(irq), 32'(|(m_stat & m_en)));
      check("R9 valid vs model", 32'(pend_valid), 32'(|(m_stat & m_en)));
      check("R9 pin vs model", 32'(pend_pin), 32'(exp_pin(m_stat & m_en)));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(6);
    chk_on = 1'b1;

    // R2: reset state
    check("R2 irq", 32'(irq), 0);
    check("R2 valid", 32'(pend_valid), 0);
    check("R2 pin", 32'(pend_pin), 0);
    rd(6'h0C, v); check("R2 enable low", 32'(v), 0);
    rd(6'h0E, v); check("R2 enable high", 32'(v), 0);
    rd(6'h12, v); check("R2 type high", 32'(v), 0);

    // All pins active-high level; idle pins low.
    wr(6'h14, 16'hFFFF); wr(6'h16, 16'hFFFF);
    step(4);
    rd(6'h08, v); check("R4 idle low inputs active-high", 32'(v), 0);

    // R1: readback and bank separation
    wr(6'h20, 16'hA5C3); rd(6'h20, v); check("R1 fall low readback", 32'(v), 32'hA5C3);
    wr(6'h26, 16'h5A3C); rd(6'h26, v); check("R1 rise high readback", 32'(v), 32'h5A3C);
    rd(6'h22, v); check("R1 fall high untouched", 32'(v), 0);
    rd(6'h24, v); check("R1 rise low untouched", 32'(v), 0);
    wr(6'h20, 16'h0000); wr(6'h26, 16'h0000);

    // R10: undefined and odd offsets
    rd(6'h00, v); check("R10 read 0x00", 32'(v), 0);
    rd(6'h1C, v); check("R10 read 0x1C", 32'(v), 0);
    rd(6'h15, v); check("R10 read odd 0x15", 32'(v), 0);
    wr(6'h1C, 16'hFFFF); wr(6'h0D, 16'hFFFF);
    rd(6'h0C, v); check("R10 odd write ignored", 32'(v), 0);
    rd(6'h1C, v); check("R10 undefined write ignored", 32'(v), 0);

    // R11 / R4: level pin 3 active high
    wr(6'h0C, 16'h0008);
    pins[3] = 1'b1;
    step(2); check("R11 not yet after two edges", 32'(irq), 0);
    step(1); check("R11 seen after three edges", 32'(irq), 1);
    check("R4 pend pin 3", 32'(pend_pin), 3);
    wr(6'h08, 16'h0008);
    rd(6'h08, v); check("R4 clear ignored while active", 32'(v[3]), 1);
    wr(6'h14, 16'hFFF7);
    step(1); check("R4 active-low polarity with high input", 32'(irq), 0);
    pins[3] = 1'b0;
    step(3); check("R4 active-low polarity with low input", 32'(irq), 1);
    wr(6'h14, 16'hFFFF);
    step(1); check("R4 level follows input low", 32'(irq), 0);
    wr(6'h0C, 16'h0000);

    // R5 / R6 / R3: pin 20 edge, hold
    wr(6'h26, 16'h0010); wr(6'h1A, 16'h0010); wr(6'h12, 16'h0010); wr(6'h0E, 16'h0010);
    pins[20] = 1'b1;
    step(3); check("R5 rising edge latched", 32'(irq), 1);
    check("R9 pend pin 20", 32'(pend_pin), 20);
    pins[20] = 1'b0;
    step(5); check("R6 hold keeps status", 32'(irq), 1);
    wr(6'h0A, 16'h0000); check("R3 write zero no effect", 32'(irq), 1);
    wr(6'h0A, 16'h0010); check("R3 write one clears", 32'(irq), 0);
    pins[20] = 1'b1; step(3);
    wr(6'h0A, 16'h0010);
    pins[20] = 1'b0;
    step(4); check("R5 falling ignored when rising only", 32'(irq), 0);
    wr(6'h26, 16'h0000); wr(6'h22, 16'h0010);
    pins[20] = 1'b1;
    step(4); check("R5 rising ignored when falling only", 32'(irq), 0);
    pins[20] = 1'b0;
    step(3); check("R5 falling edge latched", 32'(irq), 1);
    wr(6'h0A, 16'h0010);
    wr(6'h26, 16'h0010);
    pins[20] = 1'b1;
    step(3); check("R5 both edges rising", 32'(irq), 1);
    wr(6'h0A, 16'h0010);
    pins[20] = 1'b0;
    step(3); check("R5 both edges falling", 32'(irq), 1);
    wr(6'h0A, 16'h0010);
    wr(6'h22, 16'h0000); wr(6'h26, 16'h0000);
    pins[20] = 1'b1; step(4);
    pins[20] = 1'b0; step(4);
    check("R5 no qualifier no status", 32'(irq), 0);

    // R7: pin 5 edge without hold
    wr(6'h24, 16'h0020); wr(6'h10, 16'h0020); wr(6'h0C, 16'h0020);
    pins[5] = 1'b1;
    step(3); check("R7 pulse high", 32'(irq), 1);
    step(1); check("R7 pulse one cycle", 32'(irq), 0);

    // R8: pending but disabled pin 9 (level)
    wr(6'h0C, 16'h0000);
    pins[9] = 1'b1;
    step(3); check("R8 disabled pin no irq", 32'(irq), 0);
    rd(6'h08, v); check("R8 status still set", 32'(v[9]), 1);
    wr(6'h0C, 16'h0200); check("R8 enable raises irq", 32'(irq), 1);

    // R9: priority across banks
    wr(6'h0E, 16'h0002);
    pins[17] = 1'b1;
    step(3); check("R9 low bank wins", 32'(pend_pin), 9);
    pins[9] = 1'b0;
    step(3); check("R9 high bank next", 32'(pend_pin), 17);
    pins[17] = 1'b0;
    step(3); check("R9 idle valid", 32'(pend_valid), 0);
    check("R9 idle pin zero", 32'(pend_pin), 0);

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      int unsigned r;
      r = $urandom % 8;
      if (($urandom % 4) == 0) pins = pins ^ ($urandom & $urandom & $urandom);
      if (r == 0) begin
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = pick_addr($urandom); bus_wdata = 16'($urandom);
      end else if (r == 1) begin
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = pick_addr($urandom);
        #1 check("R1 random readback", 32'(bus_rdata), 32'(model_read(bus_addr)));
      end else begin
        bus_sel = 1'b0; bus_wr = 1'b0;
      end
      @(negedge clk);
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
    step(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule